// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on a byte-wide CPU register bus and turns register accesses into properly timed program and erase pulses for an on-chip flash macro. Software loads a word address, a timing value and a command, and the sequencer drives the macro's address, 16-bit write data, program strobe and erase strobe, holding each strobe for a length counted out from the timing value.

A word is programmed by arming the program command and then writing two bytes to the data register, low byte first. The second byte launches the operation. If the erase command is armed at the same time, the whole page holding the address is erased first and the word is programmed directly afterwards. An erase armed on its own starts at once. After each program the word address steps by one, so a run of words can be written by re-arming and feeding byte pairs. A pulse input from the power controller, marking a return from a deep power mode, cancels any armed command.

Top module: `flash_seq_top`

## Requirements
- R1: The internal reset is asserted asynchronously by `rst_n` low and released on the second rising clock edge after `rst_n` rises. After reset the control register reads 0x00, both address registers and the data register read 0x00, the timing register reads 0x11, and both strobes are low.
- R2: Register index 0 is control, 1 is data, 2 is address high (bits 5:0), 3 is address low (bits 7:0), 4 is timing (bits 5:0). Control bit 7 reads busy, bit 6 reads write-busy, bit 4 is the continuous-read enable (also driven on `rd_cont`), bit 1 is WRITE, bit 0 is ERASE; unused bits and unused indices read 0. `fl_addr` is {address high, address low}.
- R3: With WRITE set, the first data write stores the low byte and the second the high byte; the second write launches a program of that word, with `fl_prog` high for PROG_UNITS*16*FWT cycles starting the cycle after that write and `fl_wdata` holding the word.
- R4: Write-busy reads 1 from the cycle after the launching byte until busy drops; data-register writes made while it is 1 change neither the data register nor the word.
- R5: Writing control with ERASE=1 and WRITE=0 starts an erase two edges later: `fl_erase` is high for ERASE_UNITS*16*FWT cycles on the page selected by address bits [13:9]; ERASE reads 0 afterwards.
- R6: With ERASE and WRITE both set, the launching byte starts an erase, and `fl_prog` rises on the edge where `fl_erase` falls.
- R7: Busy reads 1 while either strobe is high and drops one cycle after the final strobe falls; the two strobes are never high together.
- R8: When a program completes, WRITE clears and the word address increases by one, wrapping from 0x3FFF to 0.
- R9: A `pm_wake` pulse clears WRITE, ERASE and the byte-pair position, so the next data writes do not launch anything.
- R10: While busy, writes to control bits 1:0, to the address registers and to the timing register are ignored; the continuous-read bit stays writable.
- R11: A timing value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register index |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pm_wake | input | 1 | Return-from-deep-power-mode pulse |
| fl_addr | output | 14 | Flash word address |
| fl_wdata | output | 16 | Flash program data |
| fl_prog | output | 1 | Program strobe |
| fl_erase | output | 1 | Page erase strobe |
| rd_cont | output | 1 | Continuous-read enable |

## Verification
The hardest situation to reach is the combined command, where the erase must hand over to the program on exactly the edge it ends while write-busy keeps blocking new data; the stimulus first programs a pattern into a word, then arms both commands and reprograms it, so the memory model only shows the new word if the erase really ran first. Writes issued mid-operation (data, command bits, address, timing) are driven while the program strobe is high, and the cancelled-command case is reached by injecting the wake pulse between the two bytes of a pair.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PROG  = 2'd2,
    ST_END   = 2'd3
  } seq_state_t;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_DATA = 3'd1;
  localparam logic [2:0] REG_AHI  = 3'd2;
  localparam logic [2:0] REG_ALO  = 3'd3;
  localparam logic [2:0] REG_TIME = 3'd4;
endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int TW    = 6,
  parameter int PRESC = 16,
  parameter int UCW   = 10
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           run,
  input  logic [TW-1:0]  fwt,
  input  logic [UCW-1:0] units,
  output logic           done
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PW-1:0]  pre_q, pre_d;
  logic [TW-1:0]  fw_q, fw_d;
  logic [UCW-1:0] unit_q, unit_d;
  logic [TW-1:0]  fwt_eff;
  logic           pre_last, fw_last, unit_tick;

  assign fwt_eff   = (fwt == '0) ? TW'(1) : fwt;
  assign pre_last  = (pre_q == PW'(PRESC - 1));
  assign fw_last   = (fw_q == fwt_eff - TW'(1));
  assign unit_tick = pre_last && fw_last;
  assign done      = run && unit_tick && (unit_q == units - UCW'(1));

  always_comb begin
    pre_d  = pre_q;
    fw_d   = fw_q;
    unit_d = unit_q;
    if (!run || done) begin
      pre_d  = '0;
      fw_d   = '0;
      unit_d = '0;
    end else begin
      pre_d = pre_last ? '0 : pre_q + PW'(1);
      if (pre_last) fw_d = fw_last ? '0 : fw_q + TW'(1);
      if (unit_tick) unit_d = unit_q + UCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      fw_q   <= '0;
      unit_q <= '0;
    end else begin
      pre_q  <= pre_d;
      fw_q   <= fw_d;
      unit_q <= unit_d;
    end
  end

  // R3 R5: the unit counter never passes the requested length
  a_r5_unit_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    run |-> (unit_q < units));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic launch,
  input  logic erase_req,
  input  logic with_erase,
  input  logic done,
  output logic busy,
  output logic swbsy,
  output logic prog_o,
  output logic erase_o,
  output logic run,
  output logic prog_done,
  output logic erase_done
);
  seq_state_t state_q, state_d;
  logic       sw_q, sw_d;

  always_comb begin
    state_d    = state_q;
    sw_d       = sw_q;
    prog_done  = 1'b0;
    erase_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = with_erase ? ST_ERASE : ST_PROG;
          sw_d    = 1'b1;
        end else if (erase_req) begin
          state_d = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (done) begin
          erase_done = 1'b1;
          state_d    = sw_q ? ST_PROG : ST_END;
        end
      end
      ST_PROG: begin
        if (done) begin
          prog_done = 1'b1;
          state_d   = ST_END;
        end
      end
      ST_END: begin
        state_d = ST_IDLE;
        sw_d    = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sw_q    <= sw_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign swbsy   = sw_q;
  assign prog_o  = (state_q == ST_PROG);
  assign erase_o = (state_q == ST_ERASE);
  assign run     = prog_o || erase_o;

  a_r7_idle_after_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(prog_o) || ($fell(erase_o) && !prog_o)) |=> !busy);
  a_r6_erase_then_prog: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(erase_o) && swbsy) |-> prog_o);
  a_r4_sw_within_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    swbsy |-> busy);
endmodule

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
#(
  parameter int          AHW     = 6,
  parameter int          ALW     = 8,
  parameter int          TW      = 6,
  parameter logic [5:0]  FWT_RST = 6'h11,
  localparam int         AW      = AHW + ALW
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [2:0]    bus_sel,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          pm_wake,
  input  logic          busy,
  input  logic          swbsy,
  input  logic          prog_done,
  input  logic          erase_done,
  output logic          wr_arm,
  output logic          er_arm,
  output logic          cont,
  output logic [AW-1:0] addr,
  output logic [TW-1:0] fwt,
  output logic [15:0]   word,
  output logic          launch
);
  logic           cont_q, cont_d, wr_q, wr_d, er_q, er_d, ptr_q, ptr_d;
  logic [7:0]     lo_q, lo_d, data_q, data_d;
  logic [15:0]    word_q, word_d;
  logic [AHW-1:0] ahi_q, ahi_d;
  logic [ALW-1:0] alo_q, alo_d;
  logic [TW-1:0]  fwt_q, fwt_d;
  logic           we_ctrl, we_data, we_ahi, we_alo, we_time;

  assign we_ctrl = bus_we && (bus_sel == REG_CTRL);
  assign we_data = bus_we && (bus_sel == REG_DATA);
  assign we_ahi  = bus_we && (bus_sel == REG_AHI);
  assign we_alo  = bus_we && (bus_sel == REG_ALO);
  assign we_time = bus_we && (bus_sel == REG_TIME);

  always_comb begin
    cont_d = cont_q;
    wr_d   = wr_q;
    er_d   = er_q;
    ptr_d  = ptr_q;
    lo_d   = lo_q;
    data_d = data_q;
    word_d = word_q;
    ahi_d  = ahi_q;
    alo_d  = alo_q;
    fwt_d  = fwt_q;
    launch = 1'b0;
    if (we_ctrl) begin
      cont_d = bus_wdata[4];
      if (!busy) begin
        wr_d  = bus_wdata[1];
        er_d  = bus_wdata[0];
        ptr_d = 1'b0;
      end
    end
    if (we_data && !swbsy) begin
      data_d = bus_wdata;
      if (wr_q) begin
        if (!ptr_q) begin
          lo_d  = bus_wdata;
          ptr_d = 1'b1;
        end else begin
          word_d = {bus_wdata, lo_q};
          ptr_d  = 1'b0;
          launch = !pm_wake;
        end
      end
    end
    if (we_ahi && !busy)  ahi_d = bus_wdata[AHW-1:0];
    if (we_alo && !busy)  alo_d = bus_wdata[ALW-1:0];
    if (we_time && !busy) fwt_d = bus_wdata[TW-1:0];
    if (prog_done) begin
      {ahi_d, alo_d} = {ahi_q, alo_q} + AW'(1);
      wr_d           = 1'b0;
    end
    if (erase_done) er_d = 1'b0;
    if (pm_wake) begin
      wr_d  = 1'b0;
      er_d  = 1'b0;
      ptr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q <= 1'b0;
      wr_q   <= 1'b0;
      er_q   <= 1'b0;
      ptr_q  <= 1'b0;
      lo_q   <= '0;
      data_q <= '0;
      word_q <= '0;
      ahi_q  <= '0;
      alo_q  <= '0;
      fwt_q  <= TW'(FWT_RST);
    end else begin
      cont_q <= cont_d;
      wr_q   <= wr_d;
      er_q   <= er_d;
      ptr_q  <= ptr_d;
      lo_q   <= lo_d;
      data_q <= data_d;
      word_q <= word_d;
      ahi_q  <= ahi_d;
      alo_q  <= alo_d;
      fwt_q  <= fwt_d;
    end
  end

  always_comb begin
    unique case (bus_sel)
      REG_CTRL: bus_rdata = {busy, swbsy, 1'b0, cont_q, 2'b00, wr_q, er_q};
      REG_DATA: bus_rdata = data_q;
      REG_AHI:  bus_rdata = 8'(ahi_q);
      REG_ALO:  bus_rdata = 8'(alo_q);
      REG_TIME: bus_rdata = 8'(fwt_q);
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign wr_arm = wr_q;
  assign er_arm = er_q;
  assign cont   = cont_q;
  assign addr   = {ahi_q, alo_q};
  assign fwt    = fwt_q;
  assign word   = word_q;

  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_data && swbsy) |=> ($stable(data_q) && $stable(word_q)));
  a_r9_wake_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    pm_wake |=> (!wr_q && !er_q && !ptr_q));
  a_r10_timing_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(fwt_q));
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top #(
  parameter int         AHW         = 6,
  parameter int         ALW         = 8,
  parameter int         TW          = 6,
  parameter int         PRESC       = 16,
  parameter int         PROG_UNITS  = 2,
  parameter int         ERASE_UNITS = 1000,
  parameter logic [5:0] FWT_RST     = 6'h11,
  localparam int        AW          = AHW + ALW,
  localparam int        UCW         = $clog2(ERASE_UNITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_sel,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          pm_wake,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_wdata,
  output logic          fl_prog,
  output logic          fl_erase,
  output logic          rd_cont
);
  logic           rs1_q, rst_i;
  logic           busy, swbsy, run, done, launch;
  logic           prog_done, erase_done, wr_arm, er_arm;
  logic [TW-1:0]  fwt;
  logic [UCW-1:0] units;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_i <= rs1_q;
    end
  end

  flash_seq_regs #(
    .AHW(AHW), .ALW(ALW), .TW(TW), .FWT_RST(FWT_RST)
  ) u_regs (
    .clk(clk), .rst_ni(rst_i),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pm_wake(pm_wake), .busy(busy), .swbsy(swbsy),
    .prog_done(prog_done), .erase_done(erase_done),
    .wr_arm(wr_arm), .er_arm(er_arm), .cont(rd_cont),
    .addr(fl_addr), .fwt(fwt), .word(fl_wdata), .launch(launch)
  );

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_i),
    .launch(launch), .erase_req(er_arm && !wr_arm), .with_erase(er_arm), .done(done),
    .busy(busy), .swbsy(swbsy), .prog_o(fl_prog), .erase_o(fl_erase), .run(run),
    .prog_done(prog_done), .erase_done(erase_done)
  );

  assign units = fl_erase ? UCW'(ERASE_UNITS) : UCW'(PROG_UNITS);

  flash_seq_timer #(
    .TW(TW), .PRESC(PRESC), .UCW(UCW)
  ) u_timer (
    .clk(clk), .rst_ni(rst_i), .run(run), .fwt(fwt), .units(units), .done(done)
  );

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(fl_prog) |-> (fl_addr == AW'($past(fl_addr) + 1'b1)));
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_i)
    (fl_prog || fl_erase) |-> (busy && !(fl_prog && fl_erase)));
endmodule

// File: tb/sim_flash_seq_top.sv
`timescale 1ns/1ps
module sim_flash_seq_top;
  localparam int PU = 2;
  localparam int EU = 1000;

  logic        clk, rst_n, bus_we, pm_wake;
  logic [2:0]  bus_sel;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [13:0] fl_addr;
  logic [15:0] fl_wdata;
  logic        fl_prog, fl_erase, rd_cont;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  flash_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pm_wake(pm_wake),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_prog(fl_prog),
    .fl_erase(fl_erase), .rd_cont(rd_cont)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural flash array: erased words read as all ones
  logic [15:0] mem [int];
  function automatic logic [15:0] mrd(input int a);
    return mem.exists(a) ? mem[a] : 16'hFFFF;
  endfunction
  always @(posedge fl_prog) begin
    #1;
    mem[int'(fl_addr)] = mrd(int'(fl_addr)) & fl_wdata;
  end
  always @(posedge fl_erase) begin
    #1;
    for (int i = 0; i < 512; i++) mem.delete(int'({fl_addr[13:9], 9'd0}) + i);
  end

  // cycle reference model
  int          rc, m_st, m_cnt;
  logic        m_cont, m_wr, m_er, m_ptr, m_sw;
  logic [7:0]  m_blo, m_data;
  logic [15:0] m_word;
  logic [13:0] m_addr;
  logic [5:0]  m_fwt;

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_cont = 0; m_wr = 0; m_er = 0; m_ptr = 0; m_sw = 0;
    m_blo = 0; m_data = 0; m_word = 0; m_addr = 0; m_fwt = 6'h11;
  endtask

  task automatic m_step();
    bit wc, wd, wh, wl, wt, p_busy, p_sw, p_wr, p_er, p_ptr, launch, pdone, edone;
    int fe;
    wc = bus_we && bus_sel == 3'd0; wd = bus_we && bus_sel == 3'd1;
    wh = bus_we && bus_sel == 3'd2; wl = bus_we && bus_sel == 3'd3;
    wt = bus_we && bus_sel == 3'd4;
    p_busy = (m_st != 0); p_sw = m_sw; p_wr = m_wr; p_er = m_er; p_ptr = m_ptr;
    launch = wd && !p_sw && p_wr && p_ptr && !pm_wake;
    pdone = 0; edone = 0;
    if (wt && !p_busy) m_fwt = bus_wdata[5:0];
    fe = (m_fwt == 0) ? 1 : int'(m_fwt);
    case (m_st)
      0: if (launch) begin
           m_st = p_er ? 1 : 2; m_cnt = (p_er ? EU : PU) * 16 * fe; m_sw = 1;
         end else if (p_er && !p_wr) begin
           m_st = 1; m_cnt = EU * 16 * fe;
         end
      1: if (m_cnt == 1) begin
           edone = 1;
           if (p_sw) begin m_st = 2; m_cnt = PU * 16 * fe; end else m_st = 3;
         end else m_cnt--;
      2: if (m_cnt == 1) begin pdone = 1; m_st = 3; end else m_cnt--;
      default: begin m_st = 0; m_sw = 0; end
    endcase
    if (wc) begin
      m_cont = bus_wdata[4];
      if (!p_busy) begin m_wr = bus_wdata[1]; m_er = bus_wdata[0]; m_ptr = 0; end
    end
    if (wd && !p_sw) begin
      m_data = bus_wdata;
      if (p_wr) begin
        if (!p_ptr) begin m_blo = bus_wdata; m_ptr = 1; end
        else begin m_word = {bus_wdata, m_blo}; m_ptr = 0; end
      end
    end
    if (wh && !p_busy) m_addr[13:8] = bus_wdata[5:0];
    if (wl && !p_busy) m_addr[7:0]  = bus_wdata;
    if (pdone) begin m_addr = m_addr + 14'd1; m_wr = 0; end
    if (edone) m_er = 0;
    if (pm_wake) begin m_wr = 0; m_er = 0; m_ptr = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rc = 0; m_reset(); end
    else if (rc < 2) rc++;
    else m_step();
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] s);
    case (s)
      3'd0: return {m_st != 0, m_sw, 1'b0, m_cont, 2'b00, m_wr, m_er};
      3'd1: return m_data;
      3'd2: return {2'b00, m_addr[13:8]};
      3'd3: return m_addr[7:0];
      3'd4: return {2'b00, m_fwt};
      default: return 8'h00;
    endcase
  endfunction

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R3 program strobe", fl_prog, m_st == 2);
      chk("R5 erase strobe", fl_erase, m_st == 1);
      chk("R8 word address", fl_addr, m_addr);
      chk("R2 continuous read pin", rd_cont, m_cont);
      chk("R7 register read vs model", bus_rdata, exp_rd(bus_sel));
      if (m_st == 2) chk("R3 program data", fl_wdata, m_word);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [7:0] e, input string tag);
    bus_sel = s;
    #1;
    chk(tag, bus_rdata, e);
  endtask

  task automatic wait_idle();
    do begin
      @(negedge clk);
      bus_sel = 3'd0;
      #1;
    end while (bus_rdata[7]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 3'd0; bus_wdata = 8'h00; pm_wake = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd0, 8'h00, "R1 control reset");
    rd(3'd4, 8'h11, "R1 timing reset");
    rd(3'd2, 8'h00, "R1 address high reset");
    rd(3'd3, 8'h00, "R1 address low reset");
    rd(3'd1, 8'h00, "R1 data reset");
    chk("R1 strobes low", {fl_prog, fl_erase}, 0);
    rd(3'd6, 8'h00, "R2 unused index");

    // R3 program one word at 0x205
    wr(3'd4, 8'h01); wr(3'd2, 8'h02); wr(3'd3, 8'h05); wr(3'd0, 8'h02);
    rd(3'd0, 8'h02, "R2 WRITE armed");
    wr(3'd1, 8'h34);
    rd(3'd0, 8'h02, "R3 single byte does not launch");
    wr(3'd1, 8'h12);
    rd(3'd0, 8'hC2, "R4 busy and write-busy");
    wr(3'd1, 8'hAA);
    rd(3'd1, 8'h12, "R4 data write ignored");
    wr(3'd0, 8'h11);
    rd(3'd0, 8'hD2, "R10 command bits ignored, cont taken");
    wr(3'd3, 8'h77);
    rd(3'd3, 8'h05, "R10 address ignored");
    wr(3'd4, 8'h05);
    rd(3'd4, 8'h01, "R10 timing ignored");
    wait_idle();
    rd(3'd0, 8'h10, "R8 WRITE cleared");
    rd(3'd3, 8'h06, "R8 address incremented");
    chk("R3 word programmed", mrd(14'h205), 16'h1234);

    // R5 erase alone
    wr(3'd0, 8'h11);
    wait_idle();
    chk("R5 page erased", mrd(14'h205), 16'hFFFF);
    rd(3'd0, 8'h10, "R5 ERASE cleared");

    // R6 erase then program
    wr(3'd0, 8'h12); wr(3'd1, 8'h0F); wr(3'd1, 8'h0F);
    wait_idle();
    chk("R3 pattern word", mrd(14'h206), 16'h0F0F);
    wr(3'd2, 8'h02); wr(3'd3, 8'h06);
    wr(3'd0, 8'h13); wr(3'd1, 8'h78); wr(3'd1, 8'h56);
    rd(3'd0, 8'hD3, "R6 write-busy during erase");
    chk("R6 erase first", fl_erase, 1);
    wait_idle();
    chk("R6 word after erase", mrd(14'h206), 16'h5678);
    rd(3'd0, 8'h10, "R6 both commands cleared");

    // R9 wake cancels
    wr(3'd0, 8'h12); wr(3'd1, 8'h11);
    @(negedge clk); pm_wake = 1'b1;
    @(negedge clk); pm_wake = 1'b0;
    rd(3'd0, 8'h10, "R9 WRITE cancelled");
    wr(3'd1, 8'h22); wr(3'd1, 8'h33);
    @(negedge clk);
    rd(3'd0, 8'h10, "R9 no launch after wake");
    chk("R9 word untouched", mrd(14'h207), 16'hFFFF);

    // R11 timing of zero, R8 wrap
    wr(3'd4, 8'h00); wr(3'd2, 8'h3F); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h12); wr(3'd1, 8'hCD); wr(3'd1, 8'hAB);
    n = 0;
    while (fl_prog) begin n++; @(negedge clk); end
    chk("R11 pulse with timing zero", n, PU * 16);
    wait_idle();
    rd(3'd2, 8'h00, "R8 wrap high");
    rd(3'd3, 8'h00, "R8 wrap low");
    chk("R3 top word", mrd(14'h3FFF), 16'hABCD);
    wr(3'd0, 8'h12); wr(3'd1, 8'h01); wr(3'd1, 8'h00);
    wait_idle();
    wr(3'd0, 8'h12); wr(3'd1, 8'h02); wr(3'd1, 8'h00);
    wait_idle();
    chk("R8 sequential word 0", mrd(0), 16'h0001);
    chk("R8 sequential word 1", mrd(1), 16'h0002);
    rd(3'd3, 8'h02, "R8 address after two");

    repeat (3) @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule